// File: doc/BRIEF.md
# Parallel Bus Peripheral Register Interface

This block sits on the peripheral side of an 8-bit asynchronous host bus. The host starts a cycle by pulling the address strobe or the data strobe low. A direction line says who sources the data on the shared bidirectional bus: when the line is high the host is reading and the peripheral drives the bus; when it is low the host is writing. The block holds one address register and a bank of data registers. A data cycle reaches the data register that the low bits of the address register select. Every register is visible to user logic as plain outputs.

The strobes, the direction line and the bus are synchronised into the system clock domain. Once the peripheral has taken in a cycle it raises the `wait_o` handshake, and the host keeps its strobe low until then. A write is committed when the strobe is released. After that commit `wait_o` drops, which tells the host the next cycle may start. The bus driver is enabled directly from the pins: it drives only while a read is under way and a strobe is low. The interrupt and reset lines pass straight through the block. No flow control is needed at the register side, because the host handshake paces every transfer and the register outputs are level signals.

Top module: `pbus_periph`

## Requirements
- R1: While `rst` is high, and at the first edge after it falls, `wait_o` is 0 and both `addr_o` and every data register in `regs_o` read 0.
- R2: An address write cycle (`astb_n` low, `host_rd` low) loads the bus value into `addr_o` when the strobe is released.
- R3: A data write cycle (`dstb_n` low, `host_rd` low) stores the bus value into data register `addr_o[3:0]`. Register k occupies `regs_o[8k+7:8k]`. Address bits 7:4 are ignored, and no other register changes.
- R4: An address read cycle (`astb_n` low, `host_rd` high) presents `addr_o` on `pbus` while the strobe is low.
- R5: A data read cycle (`dstb_n` low, `host_rd` high) presents data register `addr_o[3:0]` on `pbus` while the strobe is low.
- R6: The block drives `pbus` only while `host_rd` is high and a strobe is low. During a write cycle the bus carries the host's value unchanged.
- R7: `wait_o` rises within 4 clock cycles after a strobe goes low. It stays high for as long as that strobe is held low.
- R8: `wait_o` falls within 4 clock cycles after the strobe is released, and not while the strobe is still low. A new cycle is accepted after `wait_o` falls.
- R9: A read cycle changes neither `addr_o` nor any data register.
- R10: `host_irq_o` follows `user_irq_i`, and `user_rst_o` follows `host_rst_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| astb_n | input | 1 | Address strobe from host, active low |
| dstb_n | input | 1 | Data strobe from host, active low |
| host_rd | input | 1 | Direction: 1 = host reads, 0 = host writes |
| pbus | inout | 8 | Shared bidirectional data bus |
| wait_o | output | 1 | Handshake to host: high = cycle handled |
| host_irq_o | output | 1 | Interrupt request toward host |
| user_irq_i | input | 1 | Interrupt request from user logic |
| host_rst_i | input | 1 | Reset request from host |
| user_rst_o | output | 1 | Reset request toward user logic |
| addr_o | output | 8 | Address register contents |
| regs_o | output | 128 | Data registers, register k at bits 8k+7:8k |

## Verification
The main function is tried with write-then-read pairs on several registers. These show whether the address register actually steers data cycles, rather than a single register being reused. One write uses an address with high bits set, which separates masking of bits 7:4 from a full-width compare. A read is followed by a check of every register, which tells a read that is truly passive from one that writes the bus value back. Strobes are held low for several cycles, which shows whether `wait_o` waits for the release or drops on its own.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } pbus_state_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '1;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '1;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         astb_s,
  input  logic         dstb_s,
  input  logic         rd_s,
  input  logic [W-1:0] bus_s,
  output logic         wait_o,
  output logic         addr_we,
  output logic         reg_we,
  output logic [W-1:0] wdata
);
  pbus_state_e state;
  logic         cyc_addr;
  logic         cyc_rd;
  logic [W-1:0] bus_hold;
  logic         strobe_low;
  logic         released;

  assign strobe_low = cyc_addr ? !astb_s : !dstb_s;
  assign released   = (state == ST_HOLD) && !strobe_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cyc_addr <= 1'b0;
      cyc_rd   <= 1'b0;
      bus_hold <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!astb_s || !dstb_s) begin
            state    <= ST_HOLD;
            cyc_addr <= !astb_s;
            cyc_rd   <= rd_s;
            bus_hold <= bus_s;
          end
        end
        default: begin
          if (strobe_low) bus_hold <= bus_s;
          else            state    <= ST_IDLE;
        end
      endcase
    end
  end

  assign wait_o  = (state == ST_HOLD);
  assign addr_we = released && !cyc_rd && cyc_addr;
  assign reg_we  = released && !cyc_rd && !cyc_addr;
  assign wdata   = bus_hold;

  // R7: wait only rises after a synchronised strobe was seen low
  a_r7_wait_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |-> ($past(!astb_s) || $past(!dstb_s)));

  // R8: wait holds while the cycle's strobe is still low
  a_r8_wait_held: assert property (@(posedge clk) disable iff (rst)
    (wait_o && strobe_low) |=> wait_o);

  // R9: a read cycle never raises a write enable
  a_r9_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (wait_o && cyc_rd) |-> !(addr_we || reg_we));
endmodule

// File: rtl/pbus_regbank.sv
module pbus_regbank
  import pbus_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NREG,
  localparam int XW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [XW-1:0]  widx,
  input  logic [W-1:0]   wdata,
  input  logic [XW-1:0]  ridx,
  output logic [W-1:0]   rdata,
  output logic [N*W-1:0] flat
);
  logic [W-1:0] mem [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                             mem[i] <= '0;
        else if (we && widx == XW'(i))       mem[i] <= wdata;
      end
      assign flat[i*W +: W] = mem[i];

      // R3: only the indexed register may change
      a_r3_only_indexed: assert property (@(posedge clk) disable iff (rst)
        !(we && widx == XW'(i)) |=> $stable(flat[i*W +: W]));
    end
  endgenerate

  assign rdata = mem[ridx];
endmodule

// File: rtl/pbus_periph.sv
module pbus_periph
  import pbus_pkg::*;
#(
  parameter int DWP = DW,
  parameter int AWP = AW,
  parameter int NR  = NREG,
  localparam int XW = $clog2(NR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              astb_n,
  input  logic              dstb_n,
  input  logic              host_rd,
  inout  wire  [DWP-1:0]    pbus,
  output logic              wait_o,
  output logic              host_irq_o,
  input  logic              user_irq_i,
  input  logic              host_rst_i,
  output logic              user_rst_o,
  output logic [AWP-1:0]    addr_o,
  output logic [NR*DWP-1:0] regs_o
);
  localparam int SW = DWP + 3;

  logic [SW-1:0]  sync_q;
  logic           astb_s, dstb_s, rd_s;
  logic [DWP-1:0] bus_s;
  logic           addr_we, reg_we;
  logic [DWP-1:0] wdata;
  logic [DWP-1:0] reg_rd;
  logic [DWP-1:0] drive_val;
  logic           bus_oe;
  logic [AWP-1:0] addr_q;

  pbus_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({astb_n, dstb_n, host_rd, pbus}),
    .q   (sync_q)
  );
  assign {astb_s, dstb_s, rd_s, bus_s} = sync_q;

  pbus_ctrl #(.W(DWP)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .astb_s  (astb_s),
    .dstb_s  (dstb_s),
    .rd_s    (rd_s),
    .bus_s   (bus_s),
    .wait_o  (wait_o),
    .addr_we (addr_we),
    .reg_we  (reg_we),
    .wdata   (wdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (addr_we) addr_q <= AWP'(wdata);
  end

  pbus_regbank #(.W(DWP), .N(NR)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .widx  (addr_q[XW-1:0]),
    .wdata (wdata),
    .ridx  (addr_q[XW-1:0]),
    .rdata (reg_rd),
    .flat  (regs_o)
  );

  assign bus_oe    = host_rd && (!astb_n || !dstb_n);
  assign drive_val = !astb_n ? DWP'(addr_q) : reg_rd;
  assign pbus      = bus_oe ? drive_val : {DWP{1'bz}};

  assign addr_o     = addr_q;
  assign host_irq_o = user_irq_i;
  assign user_rst_o = host_rst_i;

  // R2: the address register moves only on a committed address write
  a_r2_addr_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !addr_we |=> $stable(addr_q));

  // R1: one edge after reset the handshake is idle and the address is zero
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!wait_o && addr_q == '0));
endmodule

// File: tb/pbus_periph_tb_top.sv
`timescale 1ns/1ps
module pbus_periph_tb_top;
  localparam int DW = 8;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic astb_n = 1'b1, dstb_n = 1'b1, host_rd = 1'b0;
  logic host_en = 1'b0;
  logic [DW-1:0] host_drv = '0;
  wire  [DW-1:0] pbus;
  logic wait_o, host_irq_o, user_irq_i = 1'b0, host_rst_i = 1'b0, user_rst_o;
  logic [7:0] addr_o;
  logic [NR*DW-1:0] regs_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] m_addr = '0;
  logic [7:0] m_regs [NR];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       wait_prev = 1'b0;

  always #4 clk = ~clk;

  assign pbus = host_en ? host_drv : {DW{1'bz}};

  pbus_periph dut_i (
    .clk(clk), .rst(rst), .astb_n(astb_n), .dstb_n(dstb_n), .host_rd(host_rd),
    .pbus(pbus), .wait_o(wait_o), .host_irq_o(host_irq_o), .user_irq_i(user_irq_i),
    .host_rst_i(host_rst_i), .user_rst_o(user_rst_o), .addr_o(addr_o), .regs_o(regs_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // monitor: read data is compared when wait rises during a read
  always @(negedge clk) begin
    if (wait_o && !wait_prev && host_rd && (!astb_n || !dstb_n)) begin
      if (exp_q.size() == 0) begin
        check("R4/R5 unexpected read", 128'(pbus), 128'hffff);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 128'(pbus), 128'(e));
      end
    end
    wait_prev <= wait_o;
  end

  task automatic bus_cycle(input bit is_addr, input bit is_rd, input logic [7:0] wd);
    int n;
    @(negedge clk);
    host_rd  = is_rd;
    host_drv = wd;
    host_en  = !is_rd;
    if (is_rd) begin
      exp_q.push_back(is_addr ? m_addr : m_regs[m_addr[3:0]]);
      tag_q.push_back(is_addr ? "R4 address read" : "R5 data read");
    end
    @(negedge clk);
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    n = 0;
    while (!wait_o && n < 20) begin @(negedge clk); n++; end
    check("R7 wait rise latency", 128'(n <= 4), 128'(1));
    repeat (5) @(negedge clk);
    check("R7 wait held during strobe", 128'(wait_o), 128'(1));
    if (!is_rd) check("R6 bus carries host value", 128'(pbus), 128'(wd));
    astb_n = 1'b1;
    dstb_n = 1'b1;
    n = 0;
    while (wait_o && n < 20) begin @(negedge clk); n++; end
    check("R8 wait fall after release", 128'(n <= 4), 128'(1));
    host_en = 1'b0;
    host_rd = 1'b0;
    if (!is_rd) begin
      if (is_addr) m_addr = wd;
      else         m_regs[m_addr[3:0]] = wd;
    end
    @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    logic [NR*DW-1:0] e;
    for (int k = 0; k < NR; k++) e[k*DW +: DW] = m_regs[k];
    check(req, 128'(regs_o), 128'(e));
    check(req, 128'(addr_o), 128'(m_addr));
  endtask

  initial begin
    for (int k = 0; k < NR; k++) m_regs[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 wait in reset", 128'(wait_o), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1 wait after reset", 128'(wait_o), 128'(0));
    check_regs("R1 registers cleared");

    user_irq_i = 1'b1; host_rst_i = 1'b1; #1;
    check("R10 irq pass", 128'(host_irq_o), 128'(1));
    check("R10 reset pass", 128'(user_rst_o), 128'(1));
    user_irq_i = 1'b0; host_rst_i = 1'b0; #1;
    check("R10 irq pass low", 128'(host_irq_o), 128'(0));

    bus_cycle(1'b1, 1'b0, 8'h03);
    check("R2 address write", 128'(addr_o), 128'h03);
    bus_cycle(1'b0, 1'b0, 8'hA5);
    check_regs("R3 data write reg3");
    bus_cycle(1'b1, 1'b1, 8'h00);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check_regs("R9 read leaves registers");

    bus_cycle(1'b1, 1'b0, 8'h2C);
    check("R2 address write high bits", 128'(addr_o), 128'h2C);
    bus_cycle(1'b0, 1'b0, 8'h5E);
    check_regs("R3 high address bits ignored reg12");
    bus_cycle(1'b0, 1'b1, 8'h00);
    bus_cycle(1'b1, 1'b1, 8'h00);

    for (int k = 0; k < NR; k += 5) begin
      bus_cycle(1'b1, 1'b0, 8'(k));
      bus_cycle(1'b0, 1'b0, 8'(8'h40 + k));
    end
    check_regs("R3 several registers");
    bus_cycle(1'b1, 1'b0, 8'h03);
    bus_cycle(1'b0, 1'b1, 8'h00);
    bus_cycle(1'b1, 1'b0, 8'h0F);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check_regs("R9 final state");

    repeat (4) @(negedge clk);
    check("R5/R4 all reads seen", 128'(exp_q.size()), 128'(0));
    finish_run();
  end
endmodule